// File: doc/BRIEF.md
# Lane Margining Command Transaction Unit

This block carries out one lane-margining control exchange with a receiver. A requester gives a lane number, a receiver number, a command type and an 8-bit payload, and says whether the command is a set command or a report command. The block builds the 16-bit command word and writes it into that lane's control register. It waits a programmable number of settle cycles and then reads back the lane's status register. From what it reads, it decides whether the exchange succeeded.

The rule for success depends on the kind of command. A set command must come back as an exact echo of the word that was written. A report command only has to return the requested type and receiver number. After that, the block writes the idle word (type 7, receiver 0, payload 0x9C, which is word 0x9C38) to the same lane. That second write must itself be echoed exactly.

Completion is a single-cycle `done` pulse together with `pass` and the payload of the first status read. `busy` is high while an exchange is running, and a request that arrives during that time is ignored. The register port is synchronous: a read issued in one cycle returns its data in the next cycle.

Top module: `lmr_cmd_xact`

## Requirements
- R1: The word written for a request is {payload[7:0], 2'b00, type[2:0], receiver[2:0]}: receiver in bits 2..0, type in bits 5..3, and payload in bits 15..8. Bits 7..6 are always zero, and the `req_rsvd` input has no effect on the written word.
- R2: Every write goes to address CAP_BASE + 8 + 4×lane. Every status read goes to CAP_BASE + 10 + 4×lane, where lane is the lane of the accepted request.
- R3: A status read is issued exactly SETTLE_CYC+1 cycles after the cycle of the write that it checks.
- R4: For a set command (`req_kind`=0), `pass` is 1 only if the status word read back equals the written word in all 16 bits.
- R5: For a report command (`req_kind`=1), if the returned bits 5..0 (type and receiver) differ from the request, the exchange ends with `pass`=0 and no second write is made.
- R6: For a report command whose returned type and receiver match, the block writes 0x9C38 to the same lane, waits, and reads again. `pass` is 1 only if that read equals 0x9C38. For every command, `resp_payload` carries bits 15..8 of the first status read.
- R7: `done` is a one-cycle pulse and ends the exchange. `busy` is high from the cycle after a request is accepted through the `done` cycle. A request seen while `busy` is high causes no register access and does not change the result.
- R8: While reset is asserted, `busy`, `done`, `reg_wr` and `reg_rd` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken only while idle |
| req_kind | input | 1 | 0 = set command, 1 = report command |
| req_lane | input | LANE_W | Target lane |
| req_rcv | input | 3 | Receiver number |
| req_type | input | 3 | Command type |
| req_payload | input | 8 | Command payload |
| req_rsvd | input | 2 | Requester's reserved bits, not used |
| busy | output | 1 | Exchange in progress |
| done | output | 1 | One-cycle completion pulse |
| pass | output | 1 | Result, valid with done |
| resp_payload | output | 8 | Payload of the first status read |
| reg_wr | output | 1 | Register write strobe |
| reg_rd | output | 1 | Register read strobe |
| reg_addr | output | ADDR_W | Register address |
| reg_wdata | output | 16 | Register write data |
| reg_rdata | input | 16 | Read data, valid the cycle after reg_rd |

## Verification
A new request can arrive in the same cycles as an exchange that is still running, including its settle wait. The bench provokes this by pulsing `req_valid` with a different lane and different fields part way through an exchange. It then judges the outcome from the register traffic and the result: the number of writes seen, their addresses, and the reported `pass` and payload must all match the first request alone. A report command can also overlap with its own follow-up idle write. A failure on the idle echo must show up in `pass` while the payload from the first read is still kept.

// File: rtl/lmr_pkg.sv
package lmr_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_WR,
    S_WAIT,
    S_RD,
    S_CHK,
    S_DONE
  } xact_state_t;

  localparam logic [2:0] IDLE_TYPE = 3'd7;
  localparam logic [2:0] IDLE_RCV  = 3'd0;
  localparam logic [7:0] IDLE_PAY  = 8'h9C;

  function automatic logic [15:0] pack_word(input logic [2:0] rcv,
                                            input logic [2:0] typ,
                                            input logic [7:0] pay);
    return {pay, 2'b00, typ, rcv};
  endfunction

endpackage

// File: rtl/lmr_settle_timer.sv
module lmr_settle_timer #(
  parameter int SETTLE_CYC = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic expired
);
  localparam int CNT_W = $clog2(SETTLE_CYC + 1);
  localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(SETTLE_CYC - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             run_q, run_d;
  logic             cnt_en;

  assign expired = run_q && (cnt_q == '0);
  assign cnt_en  = start || run_q;

  always_comb begin
    cnt_d = cnt_q;
    run_d = run_q;
    if (start) begin
      cnt_d = LOAD_VAL;
      run_d = 1'b1;
    end else if (expired) begin
      run_d = 1'b0;
    end else if (run_q) begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
      run_q <= run_d;
    end
  end

  // R3: expiry is a single-cycle event per start
  p_expire_once_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (expired && !start) |=> !expired);

endmodule

// File: rtl/lmr_lane_addr.sv
module lmr_lane_addr #(
  parameter int               LANE_W   = 5,
  parameter int               ADDR_W   = 12,
  parameter logic [ADDR_W-1:0] CAP_BASE = 12'h100
) (
  input  logic [LANE_W-1:0] lane,
  output logic [ADDR_W-1:0] ctrl_addr,
  output logic [ADDR_W-1:0] stat_addr
);
  localparam logic [ADDR_W-1:0] CTRL_OFS = ADDR_W'(8);
  localparam logic [ADDR_W-1:0] STAT_OFS = ADDR_W'(10);

  logic [ADDR_W-1:0] stride;

  assign stride    = ADDR_W'(lane) << 2;
  assign ctrl_addr = CAP_BASE + CTRL_OFS + stride;
  assign stat_addr = CAP_BASE + STAT_OFS + stride;

endmodule

// File: rtl/lmr_resp_check.sv
module lmr_resp_check (
  input  logic [15:0] sent,
  input  logic [15:0] got,
  output logic        exact,
  output logic        hdr_ok
);
  assign exact  = (got == sent);
  assign hdr_ok = (got[5:0] == sent[5:0]);
endmodule

// File: rtl/lmr_cmd_xact.sv
module lmr_cmd_xact
  import lmr_pkg::*;
#(
  parameter int                LANE_W     = 5,
  parameter int                ADDR_W     = 12,
  parameter logic [ADDR_W-1:0] CAP_BASE   = 12'h100,
  parameter int                SETTLE_CYC = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_kind,
  input  logic [LANE_W-1:0] req_lane,
  input  logic [2:0]        req_rcv,
  input  logic [2:0]        req_type,
  input  logic [7:0]        req_payload,
  input  logic [1:0]        req_rsvd,
  output logic              busy,
  output logic              done,
  output logic              pass,
  output logic [7:0]        resp_payload,
  output logic              reg_wr,
  output logic              reg_rd,
  output logic [ADDR_W-1:0] reg_addr,
  output logic [15:0]       reg_wdata,
  input  logic [15:0]       reg_rdata
);
  localparam logic [15:0] IDLE_WORD = pack_word(IDLE_RCV, IDLE_TYPE, IDLE_PAY);

  xact_state_t       state_q, state_d;
  logic              kind_q, kind_d;
  logic              phase_q, phase_d;
  logic              pass_q, pass_d;
  logic [7:0]        pay_q, pay_d;
  logic [LANE_W-1:0] lane_q, lane_d;
  logic [15:0]       word_q, word_d;
  logic              reg_en;

  logic              tmr_start, tmr_expired;
  logic              rsp_exact, rsp_hdr_ok;
  logic [ADDR_W-1:0] ctrl_addr, stat_addr;
  logic              unused_rsvd;

  assign unused_rsvd = ^req_rsvd;

  lmr_settle_timer #(.SETTLE_CYC(SETTLE_CYC)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (tmr_start),
    .expired (tmr_expired)
  );

  lmr_lane_addr #(.LANE_W(LANE_W), .ADDR_W(ADDR_W), .CAP_BASE(CAP_BASE)) u_addr (
    .lane      (lane_q),
    .ctrl_addr (ctrl_addr),
    .stat_addr (stat_addr)
  );

  lmr_resp_check u_check (
    .sent   (word_q),
    .got    (reg_rdata),
    .exact  (rsp_exact),
    .hdr_ok (rsp_hdr_ok)
  );

  always_comb begin
    state_d = state_q;
    kind_d  = kind_q;
    phase_d = phase_q;
    pass_d  = pass_q;
    pay_d   = pay_q;
    lane_d  = lane_q;
    word_d  = word_q;
    unique case (state_q)
      S_IDLE: if (req_valid) begin
        kind_d  = req_kind;
        lane_d  = req_lane;
        word_d  = pack_word(req_rcv, req_type, req_payload);
        phase_d = 1'b0;
        pass_d  = 1'b0;
        state_d = S_WR;
      end
      S_WR:   state_d = S_WAIT;
      S_WAIT: if (tmr_expired) state_d = S_RD;
      S_RD:   state_d = S_CHK;
      S_CHK: begin
        if (phase_q) begin
          pass_d  = rsp_exact;
          state_d = S_DONE;
        end else begin
          pay_d = reg_rdata[15:8];
          if (!kind_q) begin
            pass_d  = rsp_exact;
            state_d = S_DONE;
          end else if (rsp_hdr_ok) begin
            word_d  = IDLE_WORD;
            phase_d = 1'b1;
            state_d = S_WR;
          end else begin
            pass_d  = 1'b0;
            state_d = S_DONE;
          end
        end
      end
      S_DONE:  state_d = S_IDLE;
      default: state_d = S_IDLE;
    endcase
  end

  assign reg_en = (state_q == S_IDLE && req_valid) || (state_q == S_CHK);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kind_q  <= 1'b0;
      phase_q <= 1'b0;
      pass_q  <= 1'b0;
      pay_q   <= '0;
      lane_q  <= '0;
      word_q  <= '0;
    end else if (reg_en) begin
      kind_q  <= kind_d;
      phase_q <= phase_d;
      pass_q  <= pass_d;
      pay_q   <= pay_d;
      lane_q  <= lane_d;
      word_q  <= word_d;
    end
  end

  assign tmr_start    = (state_q == S_WR);
  assign reg_wr       = (state_q == S_WR);
  assign reg_rd       = (state_q == S_RD);
  assign reg_addr     = reg_rd ? stat_addr : ctrl_addr;
  assign reg_wdata    = word_q;
  assign busy         = (state_q != S_IDLE);
  assign done         = (state_q == S_DONE);
  assign pass         = pass_q;
  assign resp_payload = pay_q;

  // R1: reserved bits of any written word are zero
  p_rsvd_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |-> (reg_wdata[7:6] == 2'b00));

  // R3: a read only follows an expired settle window
  p_rd_after_settle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd |-> $past(tmr_expired));

  // R5: a header mismatch on a report ends without a second write
  p_no_retry_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_CHK && !phase_q && kind_q && !rsp_hdr_ok) |=> (done && !reg_wr));

  // R6: the follow-up write carries the idle word
  p_idle_word_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && phase_q) |-> (reg_wdata == 16'h9C38));

  // R7: done is one cycle and returns to idle
  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && !busy));

  // R7: busy holds until done
  p_busy_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> busy);

  // R2: no read and write in the same cycle
  p_rw_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr && reg_rd));

endmodule

// File: tb/lmr_cmd_xact_bench.sv
module lmr_cmd_xact_bench;
  localparam int          LANE_W = 5;
  localparam int          ADDR_W = 12;
  localparam logic [11:0] BASE   = 12'h100;
  localparam int          SETTLE = 5;

  logic clk, rst_n;
  logic req_valid, req_kind;
  logic [LANE_W-1:0] req_lane;
  logic [2:0] req_rcv, req_type;
  logic [7:0] req_payload;
  logic [1:0] req_rsvd;
  logic busy, done, pass;
  logic [7:0] resp_payload;
  logic reg_wr, reg_rd;
  logic [ADDR_W-1:0] reg_addr;
  logic [15:0] reg_wdata, reg_rdata;

  lmr_cmd_xact #(.LANE_W(LANE_W), .ADDR_W(ADDR_W), .CAP_BASE(BASE), .SETTLE_CYC(SETTLE)) u_lmr_cmd_xact (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
    .req_lane(req_lane), .req_rcv(req_rcv), .req_type(req_type),
    .req_payload(req_payload), .req_rsvd(req_rsvd), .busy(busy), .done(done),
    .pass(pass), .resp_payload(resp_payload), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  typedef struct {
    int          lane;
    logic [15:0] word;
    bit          exp_pass;
    logic [7:0]  exp_pay;
    int          exp_wr;
  } exp_t;

  exp_t sb_q[$];
  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  int wr_seen = 0;
  int wr_cyc = 0;

  logic [15:0] stat_mem [32];
  bit          ov_en;
  logic [15:0] ov_word;
  bit          corrupt_idle;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] respond(input logic [15:0] w);
    if (w == 16'h9C38) return corrupt_idle ? (w ^ 16'h0100) : w;
    if (ov_en) return ov_word;
    return w;
  endfunction

  // register model: status follows writes, read data one cycle late
  always @(posedge clk) begin
    int ri, wi;
    ri = (int'(reg_addr) - int'(BASE) - 10) >>> 2;
    wi = (int'(reg_addr) - int'(BASE) - 8) >>> 2;
    if (reg_rd === 1'b1 && ri >= 0 && ri < 32) reg_rdata <= stat_mem[ri];
    if (reg_wr === 1'b1 && wi >= 0 && wi < 32) stat_mem[wi] <= respond(reg_wdata);
  end

  // monitor / scoreboard
  always @(negedge clk) begin
    if (!rst_n) begin
      chk("R8 busy in reset", 32'(busy), 0);
      chk("R8 done in reset", 32'(done), 0);
      chk("R8 strobes in reset", 32'({reg_wr, reg_rd}), 0);
    end else begin
      cyc++;
      if (reg_wr) begin
        wr_seen++;
        if (sb_q.size() == 0) chk("R7 unexpected write", 1, 0);
        else begin
          chk("R2 write address", 32'(reg_addr), 32'(BASE) + 8 + 4 * sb_q[0].lane);
          if (wr_seen == 1) chk("R1 command word", 32'(reg_wdata), 32'(sb_q[0].word));
          else              chk("R6 idle word", 32'(reg_wdata), 32'h9C38);
        end
        wr_cyc = cyc;
      end
      if (reg_rd && sb_q.size() != 0) begin
        chk("R2 read address", 32'(reg_addr), 32'(BASE) + 10 + 4 * sb_q[0].lane);
        chk("R3 settle gap", 32'(cyc - wr_cyc), SETTLE + 1);
      end
      if (done) begin
        if (sb_q.size() == 0) chk("R7 unexpected done", 1, 0);
        else begin
          chk("R4/R5/R6 pass", 32'(pass), 32'(sb_q[0].exp_pass));
          chk("R6 resp_payload", 32'(resp_payload), 32'(sb_q[0].exp_pay));
          chk("R7 write count", 32'(wr_seen), 32'(sb_q[0].exp_wr));
          chk("R7 busy with done", 32'(busy), 1);
          void'(sb_q.pop_front());
        end
        wr_seen = 0;
      end
    end
  end

  task automatic run(input bit kind, input int lane, input logic [2:0] rcv,
                     input logic [2:0] typ, input logic [7:0] pay, input logic [1:0] rsvd,
                     input bit o_en, input logic [15:0] o_word, input bit corrupt,
                     input bit e_pass, input logic [7:0] e_pay, input int e_wr,
                     input bit spurious);
    exp_t e;
    ov_en = o_en; ov_word = o_word; corrupt_idle = corrupt;
    e.lane = lane;
    e.word = {pay, 2'b00, typ, rcv};
    e.exp_pass = e_pass; e.exp_pay = e_pay; e.exp_wr = e_wr;
    sb_q.push_back(e);
    @(negedge clk);
    chk("R7 idle before request", 32'(busy), 0);
    req_valid = 1'b1; req_kind = kind; req_lane = LANE_W'(lane);
    req_rcv = rcv; req_type = typ; req_payload = pay; req_rsvd = rsvd;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R7 busy after accept", 32'(busy), 1);
    if (spurious) begin
      repeat (3) @(negedge clk);
      req_valid = 1'b1; req_kind = 1'b0; req_lane = LANE_W'(lane ^ 7);
      req_rcv = 3'd5; req_type = 3'd2; req_payload = 8'hAA;
      @(negedge clk);
      req_valid = 1'b0;
    end
    wait (sb_q.size() == 0);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    req_valid = 0; req_kind = 0; req_lane = 0; req_rcv = 0; req_type = 0;
    req_payload = 0; req_rsvd = 0; ov_en = 0; ov_word = 0; corrupt_idle = 0;
    reg_rdata = 0;
    for (int i = 0; i < 32; i++) stat_mem[i] = 16'h0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 R4: set clear-log, reserved inputs set but ignored
    run(0, 0, 3'd1, 3'd2, 8'h55, 2'b11, 0, 0, 0, 1, 8'h55, 1, 0);
    // R4: set go-to-normal, receiver 6, lane 3
    run(0, 3, 3'd6, 3'd2, 8'h0F, 2'b10, 0, 0, 0, 1, 8'h0F, 1, 0);
    // R2 R4: set error limit 63 on top lane 31
    run(0, 31, 3'd2, 3'd2, 8'hFF, 2'b00, 0, 0, 0, 1, 8'hFF, 1, 0);
    // R4: set with status differing in payload only -> fail
    run(0, 4, 3'd1, 3'd2, 8'h55, 2'b00, 1, 16'h5411, 0, 0, 8'h54, 1, 0);
    // R6: report capabilities, matching header -> idle follow-up, pass
    run(1, 2, 3'd1, 3'd1, 8'h88, 2'b01, 1, 16'h1F09, 0, 1, 8'h1F, 2, 0);
    // R6: report max lanes on receiver 3
    run(1, 5, 3'd3, 3'd1, 8'h90, 2'b00, 1, 16'h0A0B, 0, 1, 8'h0A, 2, 0);
    // R5: wrong receiver returned -> fail, single write
    run(1, 6, 3'd1, 3'd1, 8'h89, 2'b00, 1, 16'h200A, 0, 0, 8'h20, 1, 0);
    // R5: wrong type returned -> fail, single write
    run(1, 7, 3'd2, 3'd1, 8'h8A, 2'b00, 1, 16'h3012, 0, 0, 8'h30, 1, 0);
    // R6: header matches but idle echo corrupted -> fail, payload kept
    run(1, 8, 3'd1, 3'd1, 8'h8B, 2'b00, 1, 16'h4409, 1, 0, 8'h44, 2, 0);
    // R7: request during busy is ignored
    run(0, 9, 3'd1, 3'd2, 8'h55, 2'b00, 0, 0, 0, 1, 8'h55, 1, 1);
    // R7: ignored request during a report with idle follow-up
    run(1, 10, 3'd4, 3'd1, 8'h8F, 2'b00, 1, 16'h660C, 0, 1, 8'h66, 2, 1);
    repeat (4) @(negedge clk);
    chk("R7 no activity after end", 32'({busy, reg_wr, reg_rd}), 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule